// File: doc/BRIEF.md
# Serial Word Receiver with Regenerated Word Clock

This block sits behind the line receivers of a narrow serial link and turns the incoming slot stream back into parallel words. Each cycle of the local bit clock `clk_i` carries one slot. A slot is described by two levels: a framing line `sclk_i` and a data line `sdat_i`. The block finds frame boundaries from those two levels and shifts in the data bits. It checks the closing slot and only then publishes the word on a parallel bus, together with a regenerated word clock whose timing is counted in bit times.

Three static pins pick what the surrounding chip does: receive, transmit or reset. Only receive mode lets this block drive. In every other mode it withdraws the pad enable `oe_o` and clears its state. Enabling is deferred until a whole frame has arrived, so the display side never sees a half-assembled word. The tri-state pads themselves live in the pad ring and are gated by `oe_o`.

Top module: `rx_deser`

## Requirements
- R1: Receive mode is `dir_i`=0, `sel_a_i`=1, `sel_b_i`=0. Under any other combination, from the next clock edge `oe_o` is 0, `word_o` is all zeros and `wclk_o` is 1, and serial slots arriving then produce no word.
- R2: `sel_a_i`=0 with `sel_b_i`=0 is reset mode whatever `dir_i` is: outputs go to the cleared state of R1 and stay there.
- R3: A frame is 26 slots. It opens with a start slot (`sclk_i`=0, `sdat_i`=1), carries 24 data slots (`sclk_i`=1, bit 0 first) and closes with a stop slot (`sclk_i`=0, `sdat_i`=0). `word_o` takes the word at the clock edge that samples the stop slot, and words appear in arrival order.
- R4: If the closing slot is not a valid stop (`sclk_i`=1, or `sdat_i`=1), the frame is dropped: `word_o` keeps its previous value and `wclk_o` does not go low.
- R5: After receive mode is entered, `oe_o` stays 0 until the first accepted frame, and rises at the edge that updates `word_o`.
- R6: `wclk_o` falls at the 8th clock edge after the edge that updated `word_o`, so the data is valid 8 bit times before the falling edge.
- R7: `wclk_o` stays low for exactly 13 bit times, then returns high.
- R8: With frames sent back to back, `wclk_o` has a 26-bit-time period, high 13 and low 13.
- R9: Idle slots between frames lengthen only the high phase: with a gap of G slots the high phase is 13+G bit times and the low phase is still 13.
- R10: A frame whose data slots are broken by `sclk_i`=0 is dropped. If the breaking slot is itself a start slot, a new frame begins there.
- R11: `rst_ni` low clears the block at once to `oe_o`=0, `word_o`=0 and `wclk_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock, one slot per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Direction pin, 0 selects the receive side |
| sel_a_i | input | 1 | Mode select pin A |
| sel_b_i | input | 1 | Mode select pin B |
| sclk_i | input | 1 | Framing level of the current slot |
| sdat_i | input | 1 | Data level of the current slot |
| word_o | output | 24 | Reassembled parallel word |
| wclk_o | output | 1 | Regenerated word clock, active phase low |
| oe_o | output | 1 | Pad enable for `word_o` and `wclk_o` |

## Verification
A framer that has slipped by one slot shows up as a shifted or doubled value on `word_o` at the very next stop slot. It can also show up as a good frame that is silently dropped, which leaves the word and the word clock frozen for a whole 26-cycle frame. A word-clock sequencer in the wrong count shows within one frame as a falling edge off the 8-cycle lead, or as a low phase that is not 13 cycles long. Mode-decode or enable mistakes show one edge after a pin change, as `oe_o` being driven, or released, at the wrong time.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [1:0] {
    MODE_RST = 2'd0,
    MODE_TX  = 2'd1,
    MODE_RX  = 2'd2,
    MODE_OFF = 2'd3
  } rx_mode_e;

  typedef enum logic [1:0] {
    FR_HUNT = 2'd0,
    FR_DATA = 2'd1,
    FR_STOP = 2'd2
  } fr_state_e;
endpackage

// File: rtl/rx_mode_decode.sv
module rx_mode_decode
  import rx_pkg::*;
(
  input  logic     dir_i,
  input  logic     sel_a_i,
  input  logic     sel_b_i,
  output rx_mode_e mode_o
);
  always_comb begin
    unique case ({sel_a_i, sel_b_i})
      2'b00:   mode_o = MODE_RST;
      2'b10:   mode_o = dir_i ? MODE_OFF : MODE_RX;
      2'b01:   mode_o = dir_i ? MODE_TX : MODE_OFF;
      default: mode_o = MODE_OFF;
    endcase
  end
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rx_pkg::*;
#(
  parameter int W         = 24,
  parameter bit MSB_FIRST = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         sclk_i,
  input  logic         sdat_i,
  output logic [W-1:0] word_o,
  output logic         accept_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  fr_state_e      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [W-1:0]   sh_q, sh_d;
  logic           shift_en, start_s, stop_s;

  assign start_s = !sclk_i && sdat_i;
  assign stop_s  = !sclk_i && !sdat_i;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    shift_en = 1'b0;
    accept_o = 1'b0;
    unique case (st_q)
      FR_HUNT: begin
        if (start_s) begin
          st_d  = FR_DATA;
          cnt_d = '0;
        end
      end
      FR_DATA: begin
        if (sclk_i) begin
          shift_en = 1'b1;
          if (cnt_q == CW'(W - 1)) st_d = FR_STOP;
          else cnt_d = cnt_q + 1'b1;
        end else if (start_s) begin
          cnt_d = '0;  // broken frame, restart on the new marker
        end else begin
          st_d = FR_HUNT;
        end
      end
      FR_STOP: begin
        accept_o = stop_s;
        if (start_s) begin
          st_d  = FR_DATA;
          cnt_d = '0;
        end else begin
          st_d = FR_HUNT;
        end
      end
      default: st_d = FR_HUNT;
    endcase
    if (!en_i) begin
      st_d     = FR_HUNT;
      shift_en = 1'b0;
      accept_o = 1'b0;
    end
  end

  generate
    if (MSB_FIRST) begin : g_msb_first
      assign sh_d = {sh_q[W-2:0], sdat_i};
    end else begin : g_lsb_first
      assign sh_d = {sdat_i, sh_q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= FR_HUNT;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (shift_en) sh_q <= sh_d;
    end
  end

  assign word_o = sh_q;
endmodule

// File: rtl/rx_wclk_gen.sv
module rx_wclk_gen #(
  parameter int LEAD = 8,
  parameter int LOW  = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic load_i,
  output logic wclk_o
);
  localparam int SPAN = LEAD + LOW;
  localparam int CW   = $clog2(SPAN + 1);
  localparam int SW   = CW + 1;

  logic          act_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q == CW'(SPAN - 1)) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign wclk_o = !(act_q && (cnt_q >= CW'(LEAD)));

  // checker counters: cycles since last load, length of current low run
  logic [SW-1:0] since_q, lo_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q  <= '1;
      lo_run_q <= '0;
    end else begin
      if (load_i) since_q <= '0;
      else if (since_q != '1) since_q <= since_q + 1'b1;
      if (wclk_o) lo_run_q <= '0;
      else if (lo_run_q != '1) lo_run_q <= lo_run_q + 1'b1;
    end
  end

  a_r6_fall_after_lead: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wclk_o) |-> since_q == SW'(LEAD));

  a_r7_low_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wclk_o) && $past(en_i)) |-> lo_run_q == SW'(LOW));
endmodule

// File: rtl/rx_deser.sv
module rx_deser
  import rx_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int LEAD      = 8,
  parameter int LOW       = 13,
  parameter bit MSB_FIRST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_i,
  input  logic              sel_a_i,
  input  logic              sel_b_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic [WORD_W-1:0] word_o,
  output logic              wclk_o,
  output logic              oe_o
);
  rx_mode_e          mode;
  logic              rx_en, accept;
  logic [WORD_W-1:0] sh_word;
  logic [WORD_W-1:0] out_q;
  logic              oe_q;

  rx_mode_decode u_mode (
    .dir_i   (dir_i),
    .sel_a_i (sel_a_i),
    .sel_b_i (sel_b_i),
    .mode_o  (mode)
  );

  assign rx_en = (mode == MODE_RX);

  rx_framer #(.W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_framer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (rx_en),
    .sclk_i   (sclk_i),
    .sdat_i   (sdat_i),
    .word_o   (sh_word),
    .accept_o (accept)
  );

  rx_wclk_gen #(.LEAD(LEAD), .LOW(LOW)) u_wclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en),
    .load_i (accept),
    .wclk_o (wclk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      oe_q  <= 1'b0;
    end else if (!rx_en) begin
      out_q <= '0;
      oe_q  <= 1'b0;
    end else if (accept) begin
      out_q <= sh_word;
      oe_q  <= 1'b1;
    end
  end

  assign word_o = out_q;
  assign oe_o   = oe_q;

  a_r1_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |=> (!oe_o && word_o == '0));

  a_r2_reset_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_a_i && !sel_b_i) |=> (wclk_o && !oe_o));

  a_r4_word_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en && !accept) |=> $stable(word_o));

  a_r5_enable_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(accept));
endmodule

// File: tb/tb_rx_deser.sv
module tb_rx_deser;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 24;
  localparam int LEAD = 8;
  localparam int LOW  = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir = 1'b0, sel_a = 1'b0, sel_b = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic [W-1:0] word;
  logic wclk, oe;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_deser dut (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .sel_a_i(sel_a), .sel_b_i(sel_b),
    .sclk_i(sclk), .sdat_i(sdat), .word_o(word), .wclk_o(wclk), .oe_o(oe)
  );

  // phase monitor on the word clock
  logic prev_w = 1'b1;
  int run_len = 0, low_len = 0, high_len = 0, falls = 0;
  always @(negedge clk) begin
    if (wclk == prev_w) run_len++;
    else begin
      if (prev_w) begin high_len = run_len; falls++; end
      else low_len = run_len;
      run_len = 1;
      prev_w = wclk;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic slot(input logic c, input logic d);
    sclk = c; sdat = d;
    @(negedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b0, 1'b0);
  endtask

  // kind 0: valid stop, 1: framing high in stop slot, 2: data high in stop slot
  task automatic send_frame(input logic [W-1:0] w, input int kind);
    slot(1'b0, 1'b1);
    for (int i = 0; i < W; i++) slot(1'b1, w[i]);
    case (kind)
      0: slot(1'b0, 1'b0);
      1: slot(1'b1, 1'b0);
      default: slot(1'b0, 1'b1);
    endcase
  endtask

  task automatic set_mode(input logic d, input logic a, input logic b);
    dir = d; sel_a = a; sel_b = b;
  endtask

  task automatic t_reset_state;
    check("R11 oe after reset", 32'(oe), 32'd0);
    check("R11 word after reset", 32'(word), 32'd0);
    check("R2 wclk in reset mode", 32'(wclk), 32'd1);
  endtask

  task automatic t_first_frame;
    set_mode(1'b0, 1'b1, 1'b0);
    idle(6);
    check("R5 oe before first frame", 32'(oe), 32'd0);
    send_frame(24'hA5C3_1E, 0);
    check("R3 first word", 32'(word), 32'h00A5C31E);
    check("R5 oe after first frame", 32'(oe), 32'd1);
  endtask

  task automatic t_wclk_timing;
    int first_low = -1, nlow = 0;
    logic held = 1'b1;
    idle(30);
    send_frame(24'h123456, 0);
    check("R3 word 123456", 32'(word), 32'h00123456);
    for (int k = 1; k <= 30; k++) begin
      idle(1);
      if (!wclk) begin
        nlow++;
        if (first_low < 0) first_low = k;
      end
      if (word !== 24'h123456) held = 1'b0;
    end
    check("R6 fall after lead", 32'(first_low), 32'(LEAD));
    check("R7 low length", 32'(nlow), 32'(LOW));
    check("R3 word stable in window", 32'(held), 32'd1);
  endtask

  task automatic t_back_to_back;
    logic [W-1:0] v[4] = '{24'h000001, 24'h800000, 24'h5A5A5A, 24'hFFFFFF};
    for (int i = 0; i < 4; i++) begin
      send_frame(v[i], 0);
      check("R3 word order", 32'(word), 32'(v[i]));
    end
    check("R8 high phase back to back", 32'(high_len), 32'(2*LOW + 0 - LOW));
    check("R8 low phase back to back", 32'(low_len), 32'(LOW));
    idle(30);
  endtask

  task automatic t_gapped;
    send_frame(24'h0F0F0F, 0); idle(10);
    send_frame(24'hF0F0F0, 0); idle(10);
    send_frame(24'h3C3C3C, 0);
    check("R9 high phase with gap", 32'(high_len), 32'(LEAD + LOW + 5 + 10 - LOW));
    check("R9 low phase with gap", 32'(low_len), 32'(LOW));
    check("R3 gapped word", 32'(word), 32'h003C3C3C);
    idle(30);
  endtask

  task automatic t_bad_stop;
    int f0;
    send_frame(24'hC0FFEE, 0);
    idle(30);
    f0 = falls;
    send_frame(24'h111111, 1);
    idle(30);
    check("R4 word held, framing stop", 32'(word), 32'h00C0FFEE);
    check("R4 no wclk pulse, framing stop", 32'(falls), 32'(f0));
    send_frame(24'h222222, 2);
    idle(30);
    check("R4 word held, data stop", 32'(word), 32'h00C0FFEE);
    check("R4 no wclk pulse, data stop", 32'(falls), 32'(f0));
  endtask

  task automatic t_resync;
    slot(1'b0, 1'b1);
    for (int i = 0; i < 10; i++) slot(1'b1, 1'b1);
    send_frame(24'h6B6B01, 0);
    check("R10 restart on marker", 32'(word), 32'h006B6B01);
    idle(30);
    slot(1'b0, 1'b1);
    for (int i = 0; i < 5; i++) slot(1'b1, 1'b1);
    idle(2);
    for (int i = 0; i < 19; i++) slot(1'b1, 1'b0);
    slot(1'b0, 1'b0);
    idle(30);
    check("R10 broken frame dropped", 32'(word), 32'h006B6B01);
  endtask

  task automatic t_modes;
    set_mode(1'b1, 1'b0, 1'b1);
    idle(1);
    check("R1 tx mode oe", 32'(oe), 32'd0);
    check("R1 tx mode word", 32'(word), 32'd0);
    check("R1 tx mode wclk", 32'(wclk), 32'd1);
    send_frame(24'h777777, 0);
    check("R1 frame ignored in tx mode", 32'(word), 32'd0);
    set_mode(1'b0, 1'b1, 1'b1);
    idle(1);
    check("R1 undefined mode oe", 32'(oe), 32'd0);
    set_mode(1'b0, 1'b1, 1'b0);
    idle(5);
    check("R5 oe stays low on reentry", 32'(oe), 32'd0);
    send_frame(24'h9ABCDE, 0);
    check("R5 oe after reentry frame", 32'(oe), 32'd1);
    check("R3 word after reentry", 32'(word), 32'h009ABCDE);
    idle(3);
    set_mode(1'b1, 1'b0, 1'b0);
    idle(1);
    check("R2 reset mode oe", 32'(oe), 32'd0);
    check("R2 reset mode word", 32'(word), 32'd0);
    check("R2 reset mode wclk", 32'(wclk), 32'd1);
  endtask

  task automatic t_async_reset;
    set_mode(1'b0, 1'b1, 1'b0);
    send_frame(24'h0BEEF0, 0);
    idle(9);
    #1 rst_n = 1'b0;
    #1;
    check("R11 async oe", 32'(oe), 32'd0);
    check("R11 async word", 32'(word), 32'd0);
    check("R11 async wclk", 32'(wclk), 32'd1);
    @(negedge clk); rst_n = 1'b1; #1;
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset_state();
    t_first_frame();
    t_wclk_timing();
    t_back_to_back();
    t_gapped();
    t_bad_stop();
    t_resync();
    t_modes();
    t_async_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule